// File: doc/BRIEF.md
# Split-Mode Performance Counter Bank

This block holds four physical event counters behind a simple word-addressed register port. Each physical counter runs either as one 32-bit counter or as a pair of independent 16-bit counters, so the bank offers up to eight logical counters. Event sources drive one increment strobe per logical counter. Counting happens only while the unit-enable bit in the control register is set.

Software never writes a live counter directly. A counter write lands in a per-counter holding latch and raises a latch-pending flag. The held values move into the live counters only on a control write that carries the enable bit as 1. This is true whether the unit was idle or already running, so a running unit is re-armed by rewriting its control word. Every counter or half that rolls over raises its own pending bit in the status register. Reading status returns those bits and clears them in the same access. Writing status loads the interrupt-enable mask, and one interrupt line reports any pending bit that is enabled.

The bus is 64 bits wide. Each register value occupies bits 63:32: writes take their value from there and reads return it there, with bits 31:0 read as zero. A read answers one cycle after its request.

Top module: `perfmon_bank`

## Requirements
- R1: Word address 2+n (n = 0..3) reads physical counter n's live value in bus bits 63:32, with bits 31:0 zero. Every read raises bus_rvalid with its data exactly one cycle after the request. Any other cycle leaves bus_rvalid low, and unmapped addresses 6 and 7 read as zero.
- R2: The control register sits at address 0. Register bit 31 (bus bit 63) is the unit enable. Register bits 3:0 (bus bits 35:32) give the split mode of physical counters 3..0, where 1 means a 16-bit pair and 0 means a single 32-bit counter. A read returns those five bits in the same positions and zero elsewhere.
- R3: Counters change only while the enable bit is set, apart from a commit. In 32-bit mode, physical counter n rises by one on each cycle with evt_inc[n] high, and evt_inc[n+4] has no effect on it.
- R4: In split mode, the upper 16 bits of physical counter n form logical counter n and follow evt_inc[n]. The lower 16 bits form logical counter n+4 and follow evt_inc[n+4]. No carry passes between the halves.
- R5: A write to a counter address stores the value only in that counter's latch and leaves the live value unchanged. A control write with the enable bit set loads every pending latch into its live counter at that clock edge.
- R6: While the unit is enabled, a counter write still stays in its latch until the next control write with the enable bit set. A commit clears the latch-pending flag, so a later enable write does not reload an old latch value.
- R7: A 32-bit counter stepping from 0xFFFFFFFF to 0 sets status bit n. An upper half stepping from 0xFFFF to 0 sets status bit n, and a lower half doing so sets status bit n+4.
- R8: The status register sits at address 1. A read returns pending bits 7:0 in bus bits 39:32 and clears them in the same access. A rollover in that same cycle stays pending.
- R9: A status write loads the interrupt mask from bus bits 39:32. pmu_irq is high exactly while some pending bit is also set in the mask, and a zero mask holds it low.
- R10: After reset, the control word, mask, pending bits, counters and latches are all zero, and pmu_irq and bus_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 64 | Write data; the value is in bits 63:32 |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 64 | Read data in bits 63:32; bits 31:0 are zero |
| evt_inc | input | 8 | Per-logical-counter increment strobes |
| pmu_irq | output | 1 | Interrupt: a pending bit is set in the mask |

## Verification
The bench targets rollover at both widths. A design that let the lower half carry into the upper one would corrupt logical counter n when counter n+4 wraps. One that set the wrong status bit would raise an interrupt for the wrong source. The bench writes counters both before and after enabling the unit. A design that wrote the live counter directly, or that reloaded a stale latch on a second enable write, would return values that differ from the expected count. It also reads status in the same cycle as a rollover and writes a zero mask, where a design that cleared after the set or gated the interrupt late would lose an event or hold pmu_irq high.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  // Word addresses of the register port.
  localparam int unsigned PM_ADDR_CTRL = 0;
  localparam int unsigned PM_ADDR_STAT = 1;
  localparam int unsigned PM_ADDR_CTR0 = 2;

  // Kind of access decoded from one bus request.
  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_CTRL,
    ACC_STAT,
    ACC_CTR
  } pm_acc_e;

endpackage

// File: rtl/perfmon_ctr_slice.sv
// One physical counter, its holding latch and its latch-pending flag.
module perfmon_ctr_slice #(
  parameter int unsigned CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             split_i,
  input  logic             commit_i,
  input  logic             ld_i,
  input  logic [CTR_W-1:0] ld_val_i,
  input  logic             inc_hi_i,
  input  logic             inc_lo_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic             wrap_hi_o,
  output logic             wrap_lo_o,
  output logic             lpend_o
);

  localparam int unsigned HW = CTR_W / 2;

  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic [CTR_W-1:0] lat_q;
  logic             lpend_q, lpend_d;
  logic             cnt_en, lpend_en;
  logic [HW-1:0]    hi_q, lo_q;
  logic             do_load;

  assign hi_q    = cnt_q[CTR_W-1:HW];
  assign lo_q    = cnt_q[HW-1:0];
  assign do_load = commit_i && lpend_q;

  // Next live value: a commit load wins over counting in the same cycle.
  always_comb begin
    cnt_d     = cnt_q;
    wrap_hi_o = 1'b0;
    wrap_lo_o = 1'b0;
    if (do_load) begin
      cnt_d = lat_q;
    end else if (run_i) begin
      if (split_i) begin
        if (inc_hi_i) begin
          cnt_d[CTR_W-1:HW] = hi_q + 1'b1;
          wrap_hi_o         = &hi_q;
        end
        if (inc_lo_i) begin
          cnt_d[HW-1:0] = lo_q + 1'b1;
          wrap_lo_o     = &lo_q;
        end
      end else if (inc_hi_i) begin
        cnt_d     = cnt_q + 1'b1;
        wrap_hi_o = &cnt_q;
      end
    end
  end

  assign cnt_en = do_load || (run_i && (inc_hi_i || (split_i && inc_lo_i)));

  always_comb begin
    lpend_d = lpend_q;
    if (ld_i) begin
      lpend_d = 1'b1;
    end else if (do_load) begin
      lpend_d = 1'b0;
    end
  end

  assign lpend_en = ld_i || do_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lat_q   <= '0;
      lpend_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (ld_i) begin
        lat_q <= ld_val_i;
      end
      if (lpend_en) begin
        lpend_q <= lpend_d;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign lpend_o = lpend_q;

endmodule

// File: rtl/perfmon_regif.sv
// Register port: decode, control word, status/mask, read path, interrupt.
module perfmon_regif
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_PHYS = 4,
  parameter int unsigned CTR_W    = 32,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [CTR_W-1:0]               word_i,
  input  logic [NUM_PHYS-1:0][CTR_W-1:0] cnt_i,
  input  logic [2*NUM_PHYS-1:0]          wrap_i,
  output logic                           run_o,
  output logic [NUM_PHYS-1:0]            split_o,
  output logic                           commit_o,
  output logic [NUM_PHYS-1:0]            ld_o,
  output logic [2*NUM_PHYS-1:0]          pend_o,
  output logic                           irq_o,
  output logic                           rvalid_o,
  output logic [CTR_W-1:0]               rword_o
);

  localparam int unsigned NUM_LOG = 2 * NUM_PHYS;
  localparam int unsigned EN_BIT  = CTR_W - 1;

  pm_acc_e              acc_kind;
  logic                 ctrl_wr, stat_wr, stat_rd, any_rd;
  logic                 run_q, run_d;
  logic [NUM_PHYS-1:0]  split_q, split_d;
  logic [NUM_LOG-1:0]   mask_q, mask_d;
  logic [NUM_LOG-1:0]   pend_q, pend_d;
  logic [CTR_W-1:0]     rword_q, rd_val;
  logic                 rvalid_q;

  // Access decode.
  always_comb begin
    acc_kind = ACC_IDLE;
    if (req_i) begin
      if (addr_i == ADDR_W'(PM_ADDR_CTRL)) begin
        acc_kind = ACC_CTRL;
      end else if (addr_i == ADDR_W'(PM_ADDR_STAT)) begin
        acc_kind = ACC_STAT;
      end else if ((32'(addr_i) >= PM_ADDR_CTR0) &&
                   (32'(addr_i) < PM_ADDR_CTR0 + NUM_PHYS)) begin
        acc_kind = ACC_CTR;
      end
    end
  end

  assign ctrl_wr  = (acc_kind == ACC_CTRL) && we_i;
  assign stat_wr  = (acc_kind == ACC_STAT) && we_i;
  assign stat_rd  = (acc_kind == ACC_STAT) && !we_i;
  assign any_rd   = req_i && !we_i;
  assign commit_o = ctrl_wr && word_i[EN_BIT];

  // Per-counter latch write strobes.
  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_ld
    assign ld_o[n] = (acc_kind == ACC_CTR) && we_i &&
                     (addr_i == ADDR_W'(PM_ADDR_CTR0 + n));
  end

  // Next state of control, mask and pending bits.
  always_comb begin
    run_d   = word_i[EN_BIT];
    split_d = word_i[NUM_PHYS-1:0];
    mask_d  = word_i[NUM_LOG-1:0];
    pend_d  = pend_q;
    if (stat_rd) begin
      pend_d = '0;
    end
    pend_d = pend_d | wrap_i;
  end

  // Read data selection.
  always_comb begin
    rd_val = '0;
    case (acc_kind)
      ACC_CTRL: begin
        rd_val[EN_BIT]         = run_q;
        rd_val[NUM_PHYS-1:0]   = split_q;
      end
      ACC_STAT: rd_val[NUM_LOG-1:0] = pend_q;
      ACC_CTR: begin
        for (int unsigned n = 0; n < NUM_PHYS; n++) begin
          if (addr_i == ADDR_W'(PM_ADDR_CTR0 + n)) begin
            rd_val = cnt_i[n];
          end
        end
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      split_q  <= '0;
      mask_q   <= '0;
      pend_q   <= '0;
      rword_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_q   <= run_d;
        split_q <= split_d;
      end
      if (stat_wr) begin
        mask_q <= mask_d;
      end
      pend_q   <= pend_d;
      if (any_rd) begin
        rword_q <= rd_val;
      end
      rvalid_q <= any_rd;
    end
  end

  assign run_o    = run_q;
  assign split_o  = split_q;
  assign pend_o   = pend_q;
  assign irq_o    = |(pend_q & mask_q);
  assign rvalid_o = rvalid_q;
  assign rword_o  = rword_q;

endmodule

// File: rtl/perfmon_bank.sv
// Four physical counters, each splittable into two 16-bit halves.
module perfmon_bank #(
  parameter int unsigned NUM_PHYS = 4,
  parameter int unsigned CTR_W    = 32,
  parameter int unsigned ADDR_W   = $clog2(NUM_PHYS + 2),
  parameter int unsigned NUM_LOG  = 2 * NUM_PHYS,
  parameter int unsigned BUS_W    = 2 * CTR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic               bus_rvalid,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NUM_LOG-1:0] evt_inc,
  output logic               pmu_irq
);

  logic [CTR_W-1:0]               wr_word;
  logic [CTR_W-1:0]               rd_word;
  logic                           run_en;
  logic                           commit_stb;
  logic [NUM_PHYS-1:0]            split_md;
  logic [NUM_PHYS-1:0]            ld_stb;
  logic [NUM_PHYS-1:0]            lpend_bits;
  logic [NUM_PHYS-1:0][CTR_W-1:0] ctr_val;
  logic [NUM_LOG-1:0]             wrap_ev;
  logic [NUM_LOG-1:0]             pend_bits;
  logic                           unused_wlow;

  assign wr_word     = bus_wdata[BUS_W-1:CTR_W];
  assign unused_wlow = ^bus_wdata[CTR_W-1:0];
  assign bus_rdata   = {rd_word, {CTR_W{1'b0}}};

  perfmon_regif #(
    .NUM_PHYS (NUM_PHYS),
    .CTR_W    (CTR_W),
    .ADDR_W   (ADDR_W)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (bus_req),
    .we_i     (bus_we),
    .addr_i   (bus_addr),
    .word_i   (wr_word),
    .cnt_i    (ctr_val),
    .wrap_i   (wrap_ev),
    .run_o    (run_en),
    .split_o  (split_md),
    .commit_o (commit_stb),
    .ld_o     (ld_stb),
    .pend_o   (pend_bits),
    .irq_o    (pmu_irq),
    .rvalid_o (bus_rvalid),
    .rword_o  (rd_word)
  );

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_slice
    perfmon_ctr_slice #(
      .CTR_W (CTR_W)
    ) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_en),
      .split_i   (split_md[n]),
      .commit_i  (commit_stb),
      .ld_i      (ld_stb[n]),
      .ld_val_i  (wr_word),
      .inc_hi_i  (evt_inc[n]),
      .inc_lo_i  (evt_inc[n + NUM_PHYS]),
      .cnt_o     (ctr_val[n]),
      .wrap_hi_o (wrap_ev[n]),
      .wrap_lo_o (wrap_ev[n + NUM_PHYS]),
      .lpend_o   (lpend_bits[n])
    );
  end

endmodule

// File: rtl/perfmon_bank_chk.sv
// Property checker bound into perfmon_bank.
module perfmon_bank_chk #(
  parameter int unsigned NUM_PHYS = 4,
  parameter int unsigned CTR_W    = 32,
  parameter int unsigned ADDR_W   = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_req,
  input logic                           bus_we,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [2*CTR_W-1:0]             bus_wdata,
  input logic                           bus_rvalid,
  input logic [2*NUM_PHYS-1:0]          evt_inc,
  input logic                           pmu_irq,
  input logic                           run_en,
  input logic                           commit_stb,
  input logic [NUM_PHYS-1:0]            split_md,
  input logic [NUM_PHYS-1:0]            lpend_bits,
  input logic [NUM_PHYS-1:0][CTR_W-1:0] ctr_val,
  input logic [2*NUM_PHYS-1:0]          wrap_ev,
  input logic [2*NUM_PHYS-1:0]          pend_bits
);

  localparam int unsigned NUM_LOG = 2 * NUM_PHYS;
  localparam int unsigned HW      = CTR_W / 2;

  logic rd_req, stat_rd, stat_wr0, ctr_wr;

  assign rd_req   = bus_req && !bus_we;
  assign stat_rd  = rd_req && (bus_addr == ADDR_W'(1));
  assign stat_wr0 = bus_req && bus_we && (bus_addr == ADDR_W'(1)) &&
                    (bus_wdata[CTR_W +: NUM_LOG] == '0);
  assign ctr_wr   = bus_req && bus_we && (32'(bus_addr) >= 2) &&
                    (32'(bus_addr) < 2 + NUM_PHYS);

  AST_RVALID_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R1
  AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid); // R1
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !commit_stb) |=> $stable(ctr_val)); // R3
  AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_wr && evt_inc == '0) |=> $stable(ctr_val)); // R5
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> (lpend_bits == '0)); // R6
  AST_WRAP_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev != '0) |=> ((pend_bits & $past(wrap_ev)) == $past(wrap_ev))); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && wrap_ev == '0) |=> (pend_bits == '0)); // R8
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr0 |=> !pmu_irq); // R9

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_iso
    AST_NO_HALF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !commit_stb && split_md[n] && !evt_inc[n] && evt_inc[n + NUM_PHYS])
      |=> $stable(ctr_val[n][CTR_W-1:HW])); // R4
  end

endmodule

bind perfmon_bank perfmon_bank_chk #(
  .NUM_PHYS (NUM_PHYS),
  .CTR_W    (CTR_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .evt_inc    (evt_inc),
  .pmu_irq    (pmu_irq),
  .run_en     (run_en),
  .commit_stb (commit_stb),
  .split_md   (split_md),
  .lpend_bits (lpend_bits),
  .ctr_val    (ctr_val),
  .wrap_ev    (wrap_ev),
  .pend_bits  (pend_bits)
);

// File: tb/perfmon_bank_bench.sv
`timescale 1ns/1ps
module perfmon_bank_bench;

  localparam int NP = 4;
  localparam int NL = 8;
  localparam int AW = 3;

  logic          clk;
  logic          rst_n;
  logic          bus_req;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [63:0]   bus_wdata;
  logic          bus_rvalid;
  logic [63:0]   bus_rdata;
  logic [NL-1:0] evt_inc;
  logic          pmu_irq;

  perfmon_bank u_perfmon_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .evt_inc    (evt_inc),
    .pmu_irq    (pmu_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] last_rd;

  // Reference model state.
  logic [31:0]   m_cnt [NP];
  logic [31:0]   m_lat [NP];
  logic [NP-1:0] m_lp;
  logic [NP-1:0] m_split;
  logic          m_en;
  logic [NL-1:0] m_pend;
  logic [NL-1:0] m_mask;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    if (a == 0) return {m_en, 27'd0, m_split};
    if (a == 1) return {24'd0, m_pend};
    if (a >= 2 && a < 2 + NP) return m_cnt[int'(a) - 2];
    return 32'd0;
  endfunction

  // One bus cycle: drive at negedge, update model at the edge, check at next negedge.
  task automatic step(input logic rq, input logic w, input logic [AW-1:0] a,
                      input logic [31:0] v, input logic [NL-1:0] ev);
    logic [31:0]   exp_rd;
    logic [NL-1:0] wset;
    logic          cm;
    string         tg;
    bus_req   = rq;
    bus_we    = w;
    bus_addr  = a;
    bus_wdata = {v, $urandom()};
    evt_inc   = ev;
    exp_rd    = model_read(a);
    tg        = (a == 0) ? "R2" : (a == 1) ? "R8" : "R1";
    @(posedge clk);
    wset = '0;
    cm   = rq && w && (a == 0) && v[31];
    for (int n = 0; n < NP; n++) begin
      if (cm && m_lp[n]) begin
        m_cnt[n] = m_lat[n];
        m_lp[n]  = 1'b0;
      end else if (m_en) begin
        if (m_split[n]) begin
          if (ev[n]) begin
            if (m_cnt[n][31:16] == 16'hFFFF) wset[n] = 1'b1;
            m_cnt[n][31:16] = m_cnt[n][31:16] + 16'd1;
          end
          if (ev[n+NP]) begin
            if (m_cnt[n][15:0] == 16'hFFFF) wset[n+NP] = 1'b1;
            m_cnt[n][15:0] = m_cnt[n][15:0] + 16'd1;
          end
        end else if (ev[n]) begin
          if (m_cnt[n] == 32'hFFFF_FFFF) wset[n] = 1'b1;
          m_cnt[n] = m_cnt[n] + 32'd1;
        end
      end
    end
    if (rq && w) begin
      if (a == 0) begin
        m_en    = v[31];
        m_split = v[NP-1:0];
      end else if (a == 1) begin
        m_mask = v[NL-1:0];
      end else if (a < 2 + NP) begin
        m_lat[int'(a) - 2] = v;
        m_lp[int'(a) - 2]  = 1'b1;
      end
    end
    if (rq && !w && a == 1) m_pend = '0;
    m_pend = m_pend | wset;
    @(negedge clk);
    chk("R1", {63'd0, bus_rvalid}, {63'd0, rq && !w});
    if (rq && !w) begin
      chk(tg, bus_rdata, {exp_rd, 32'd0});
      last_rd = bus_rdata[63:32];
    end
    chk("R9", {63'd0, pmu_irq}, {63'd0, |(m_pend & m_mask)});
    bus_req = 1'b0;
    bus_we  = 1'b0;
    evt_inc = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] v);
    step(1'b1, 1'b1, a, v, '0);
  endtask

  task automatic idle(input logic [NL-1:0] ev, input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b0, 1'b0, '0, 32'd0, ev);
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    step(1'b1, 1'b0, a, 32'd0, '0);
    chk(tag, {32'd0, last_rd}, {32'd0, exp});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; evt_inc = '0; last_rd = '0;
    for (int n = 0; n < NP; n++) begin m_cnt[n] = '0; m_lat[n] = '0; end
    m_lp = '0; m_split = '0; m_en = 1'b0; m_pend = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10", {63'd0, pmu_irq}, 64'd0);
    chk("R10", {63'd0, bus_rvalid}, 64'd0);
    rd_exp(0, 32'd0, "R10");
    rd_exp(1, 32'd0, "R10");
    for (int n = 0; n < NP; n++) rd_exp(AW'(2 + n), 32'd0, "R10");

    // R5 latch only while disabled, then commit on enable
    wr(2, 32'h1234_5678);
    idle(8'hFF, 3);
    rd_exp(2, 32'd0, "R5");
    wr(0, 32'h8000_0000);
    rd_exp(2, 32'h1234_5678, "R5");

    // R3 32-bit mode ignores the lower strobe
    idle(8'h10, 3);
    idle(8'h01, 2);
    rd_exp(2, 32'h1234_567A, "R3");

    // R6 write while enabled stays latched; commit once only
    wr(2, 32'hAAAA_0000);
    rd_exp(2, 32'h1234_567A, "R6");
    wr(0, 32'h8000_0000);
    rd_exp(2, 32'hAAAA_0000, "R6");
    idle(8'h01, 1);
    wr(0, 32'h8000_0000);
    rd_exp(2, 32'hAAAA_0001, "R6");

    // R4 split mode, lower half wraps without carry; R7 pend bit 5
    wr(0, 32'h8000_0002);
    wr(1, 32'h0000_00FF);
    wr(3, 32'h0001_FFFF);
    wr(0, 32'h8000_0002);
    idle(8'h20, 1);
    rd_exp(3, 32'h0001_0000, "R4");
    chk("R9", {63'd0, pmu_irq}, 64'd1);
    rd_exp(1, 32'h0000_0020, "R7");
    rd_exp(1, 32'h0000_0000, "R8");
    chk("R8", {63'd0, pmu_irq}, 64'd0);

    // R7 32-bit wrap, then R9 zero mask drops the interrupt
    wr(4, 32'hFFFF_FFFF);
    wr(0, 32'h8000_0002);
    idle(8'h04, 1);
    rd_exp(4, 32'h0000_0000, "R7");
    chk("R9", {63'd0, pmu_irq}, 64'd1);
    wr(1, 32'h0000_0000);
    chk("R9", {63'd0, pmu_irq}, 64'd0);
    rd_exp(1, 32'h0000_0004, "R8");

    // R4 upper half wrap sets bit n
    wr(3, 32'hFFFF_0005);
    wr(0, 32'h8000_0002);
    idle(8'h02, 1);
    rd_exp(3, 32'h0000_0005, "R4");
    rd_exp(1, 32'h0000_0002, "R7");

    // R3 disabled counters hold
    wr(0, 32'h0000_0000);
    idle(8'hFF, 2);
    rd_exp(2, 32'hAAAA_0001, "R3");

    // R2 control readback keeps only enable and split bits
    wr(0, 32'h8000_00F5);
    rd_exp(0, 32'h8000_0005, "R2");

    // R1 unmapped addresses read zero
    rd_exp(6, 32'd0, "R1");
    rd_exp(7, 32'd0, "R1");

    // Random phase against the model.
    for (int i = 0; i < 4000; i++) begin
      int sel;
      a   = AW'($urandom() % 8);
      sel = int'($urandom() % 4);
      v   = (sel == 0) ? 32'hFFFF_FFFF : (sel == 1) ? 32'h0000_FFFE :
            (sel == 2) ? 32'hFFFE_FFFF : $urandom();
      if (a == 0) v = {($urandom() % 4) != 0, 27'd0, 4'($urandom())};
      step(1'($urandom()), 1'($urandom()), a, v, NL'($urandom()));
    end

    finish_run();
  end

endmodule